// File: doc/BRIEF.md
# Two-Thread Level Interrupt Controller with Paired Shadow Enables

This block gathers 40 level-sensitive interrupt lines and presents them to two hardware threads, CPU0 and CPU1, through one interrupt output each. Software sees the block through a small 32-bit register bus. It uses the bus to set enable bits, which are split across a low word and a high word, and to read the current line status from two pending words.

An ordinary line is delivered only to CPU0, and only while its own enable bit is 1. Some lines must reach both threads. For each of these, the integrator assigns a spare "shadow" line number through the `PAIR_MAP` parameter. The target's own enable bit then gates the line towards CPU0. The shadow's enable bit gates the same physical line towards CPU1. A shadow number has no source of its own: its input pin is ignored and its pending bit always reads 0.

Line inputs are registered once before they are used, and both interrupt outputs are registered. Read data returns one clock after the address is presented.

Top module: `dual_cpu_irq_ctrl`

## Requirements
- R1: After synchronous reset, all enable bits are 0, both interrupt outputs are low, and every register reads 0.
- R2: The enable word at address 0x04 holds bit n for line n (n = 0..31). A write takes effect at the clock edge that samples it, and the word reads back the last value written. A 1 enables the line; a 0 blocks it.
- R3: The enable word at address 0x50 holds bit n-32 for line n (n = 32..39). Bits 8..31 of this word read 0 and ignore writes.
- R4: The pending word at address 0x08 shows, in bit n, the level of line n (n = 0..31), registered once. The bit stays 1 while the line is held high and returns to 0 once the line drops, whatever the enable bits hold.
- R5: The pending word at address 0x54 shows line n in bit n-32 (n = 32..39). Bits 8..31 read 0.
- R6: A shadow line number never appears as pending, and its input pin never drives either output.
- R7: CPU0's output equals the OR, over all non-shadow lines, of (registered line AND that line's own enable bit). It is registered, so a line or enable change reaches the pin two clock edges after it is applied.
- R8: CPU1's output equals the OR, over all target/shadow pairs, of (registered target line AND the shadow's enable bit). A line without a shadow never reaches CPU1.
- R9: For a paired line, the target's own enable bit has no effect on CPU1, and the shadow's enable bit has no effect on CPU0.
- R10: Writes to the pending words or to any other address change no enable bit, and reads of unused addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after the address |
| irq_lines_i | input | 40 | Level-sensitive interrupt lines |
| cpu0_irq_o | output | 1 | Interrupt request to CPU0 |
| cpu1_irq_o | output | 1 | Interrupt request to CPU1 |

## Verification
An enable-word write and a change of the line levels can land in the same clock cycle. Masking and delivery then race through the enable register and the line register into the output flops.

The random phase provokes this by driving new line levels and a bus write on the same falling edge. It then compares both outputs and all register reads against a model computed in the bench from the enable state written and the lines applied.

A directed case pins the two-edge latency from an enable write to CPU0's pin. A checker assertion ties each output, cycle by cycle, to the previous cycle's pending and enable state.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  localparam int unsigned   MAX_SRC  = 64;
  localparam logic [7:0]    NO_PAIR  = 8'hFF;

  localparam logic [7:0] OFF_EN_LO   = 8'h04;
  localparam logic [7:0] OFF_PEND_LO = 8'h08;
  localparam logic [7:0] OFF_EN_HI   = 8'h50;
  localparam logic [7:0] OFF_PEND_HI = 8'h54;

  // Default pairing: line 30 shadowed by 29, line 5 shadowed by 38.
  function automatic logic [MAX_SRC*8-1:0] default_pairs();
    logic [MAX_SRC*8-1:0] m;
    m = '1;
    m[30*8 +: 8] = 8'd29;
    m[5*8  +: 8] = 8'd38;
    return m;
  endfunction

  // Marks every line number named as a shadow by some target.
  function automatic logic [MAX_SRC-1:0] shadow_set(input int n,
                                                    input logic [MAX_SRC*8-1:0] map);
    logic [MAX_SRC-1:0] s;
    s = '0;
    for (int t = 0; t < n; t++) begin
      if (map[t*8 +: 8] != NO_PAIR && int'(map[t*8 +: 8]) < n)
        s[map[t*8 +: 8]] = 1'b1;
    end
    return s;
  endfunction

endpackage

// File: rtl/irq_en_regs.sv
module irq_en_regs
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_SRC-1:0] pend_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic [DATA_W-1:0]  rdata_o
);

  localparam int unsigned HI_W = NUM_SRC - DATA_W;
  localparam logic [ADDR_W-1:0] A_EN_LO   = ADDR_W'(OFF_EN_LO);
  localparam logic [ADDR_W-1:0] A_PEND_LO = ADDR_W'(OFF_PEND_LO);
  localparam logic [ADDR_W-1:0] A_EN_HI   = ADDR_W'(OFF_EN_HI);
  localparam logic [ADDR_W-1:0] A_PEND_HI = ADDR_W'(OFF_PEND_HI);

  logic [DATA_W-1:0] en_lo_q;
  logic [HI_W-1:0]   en_hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_lo_q <= '0;
      en_hi_q <= '0;
    end else if (wr_i) begin
      if (addr_i == A_EN_LO) en_lo_q <= wdata_i;
      if (addr_i == A_EN_HI) en_hi_q <= wdata_i[HI_W-1:0];
    end
  end

  assign en_o = {en_hi_q, en_lo_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else begin
      case (addr_i)
        A_EN_LO:   rdata_o <= en_lo_q;
        A_EN_HI:   rdata_o <= DATA_W'(en_hi_q);
        A_PEND_LO: rdata_o <= pend_i[DATA_W-1:0];
        A_PEND_HI: rdata_o <= DATA_W'(pend_i[NUM_SRC-1:DATA_W]);
        default:   rdata_o <= '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned          NUM_SRC  = 40,
  parameter logic [NUM_SRC*8-1:0] PAIR_MAP = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] lines_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic               cpu0_o,
  output logic               cpu1_o
);

  localparam logic [MAX_SRC-1:0] SHADOW_ALL =
    shadow_set(NUM_SRC, (MAX_SRC*8)'(PAIR_MAP));
  localparam logic [NUM_SRC-1:0] SHADOW = SHADOW_ALL[NUM_SRC-1:0];

  logic [NUM_SRC-1:0] line_q;
  logic [NUM_SRC-1:0] via_cpu1;

  // Shadow numbers have no source: their pins are dropped here.
  always_ff @(posedge clk) begin
    if (rst) line_q <= '0;
    else     line_q <= lines_i & ~SHADOW;
  end

  assign pend_o = line_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_pair
    localparam int unsigned SH = int'(PAIR_MAP[g*8 +: 8]);
    if (PAIR_MAP[g*8 +: 8] != NO_PAIR && SH < NUM_SRC) begin : g_on
      assign via_cpu1[g] = line_q[g] & en_i[SH];
    end else begin : g_off
      assign via_cpu1[g] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu0_o <= 1'b0;
      cpu1_o <= 1'b0;
    end else begin
      cpu0_o <= |(line_q & en_i);
      cpu1_o <= |via_cpu1;
    end
  end

endmodule

// File: rtl/dual_cpu_irq_ctrl.sv
module dual_cpu_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned          NUM_SRC  = 40,
  parameter int unsigned          ADDR_W   = 8,
  parameter int unsigned          DATA_W   = 32,
  parameter logic [NUM_SRC*8-1:0] PAIR_MAP = (NUM_SRC*8)'(default_pairs())
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] irq_lines_i,
  output logic               cpu0_irq_o,
  output logic               cpu1_irq_o
);

  logic [NUM_SRC-1:0] en_w;
  logic [NUM_SRC-1:0] pend_w;

  irq_en_regs #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
  ) regs_i (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (bus_addr),
    .wr_i    (bus_wr),
    .wdata_i (bus_wdata),
    .pend_i  (pend_w),
    .en_o    (en_w),
    .rdata_o (bus_rdata)
  );

  irq_route #(
    .NUM_SRC  (NUM_SRC),
    .PAIR_MAP (PAIR_MAP)
  ) route_i (
    .clk     (clk),
    .rst     (rst),
    .lines_i (irq_lines_i),
    .en_i    (en_w),
    .pend_o  (pend_w),
    .cpu0_o  (cpu0_irq_o),
    .cpu1_o  (cpu1_irq_o)
  );

endmodule

// File: rtl/dual_cpu_irq_ctrl_chk.sv
module dual_cpu_irq_ctrl_chk
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned          NUM_SRC  = 40,
  parameter int unsigned          ADDR_W   = 8,
  parameter int unsigned          DATA_W   = 32,
  parameter logic [NUM_SRC*8-1:0] PAIR_MAP = '1
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [NUM_SRC-1:0] irq_lines_i,
  input logic [NUM_SRC-1:0] en_w,
  input logic [NUM_SRC-1:0] pend_w,
  input logic               cpu0_irq_o,
  input logic               cpu1_irq_o
);

  localparam logic [MAX_SRC-1:0] SH_ALL =
    shadow_set(NUM_SRC, (MAX_SRC*8)'(PAIR_MAP));
  localparam logic [NUM_SRC-1:0] SH = SH_ALL[NUM_SRC-1:0];
  localparam int unsigned HI_W = NUM_SRC - DATA_W;

  logic cpu1_want;
  always_comb begin
    cpu1_want = 1'b0;
    for (int t = 0; t < NUM_SRC; t++) begin
      if (PAIR_MAP[t*8 +: 8] != NO_PAIR && int'(PAIR_MAP[t*8 +: 8]) < NUM_SRC)
        cpu1_want = cpu1_want | (pend_w[t] & en_w[PAIR_MAP[t*8 +: 8]]);
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (en_w == '0 && !cpu0_irq_o && !cpu1_irq_o && bus_rdata == '0));

  assert_en_lo_write_R2: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr && bus_addr == ADDR_W'(OFF_EN_LO)) && !$past(rst)
      |-> en_w[DATA_W-1:0] == $past(bus_wdata));

  assert_hi_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == ADDR_W'(OFF_EN_HI) || $past(bus_addr) == ADDR_W'(OFF_PEND_HI))
      |-> bus_rdata[DATA_W-1:HI_W] == '0);

  assert_pend_tracks_line_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pend_w == ($past(irq_lines_i) & ~SH));

  assert_shadow_never_pending_R6: assert property (@(posedge clk) disable iff (rst)
    (pend_w & SH) == '0);

  assert_cpu0_follows_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cpu0_irq_o == $past(|(pend_w & en_w)));

  assert_cpu1_follows_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cpu1_irq_o == $past(cpu1_want));

endmodule

bind dual_cpu_irq_ctrl dual_cpu_irq_ctrl_chk #(
  .NUM_SRC  (NUM_SRC),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .PAIR_MAP (PAIR_MAP)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .irq_lines_i (irq_lines_i),
  .en_w        (en_w),
  .pend_w      (pend_w),
  .cpu0_irq_o  (cpu0_irq_o),
  .cpu1_irq_o  (cpu1_irq_o)
);

// File: tb/dual_cpu_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module dual_cpu_irq_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [39:0] lines = '0;
  logic        cpu0, cpu1;

  int n_chk = 0;
  int n_bad = 0;

  // Bench's own view of the pairing: target 30 -> shadow 29, target 5 -> shadow 38.
  localparam logic [39:0] SHADOWS = (40'd1 << 29) | (40'd1 << 38);

  logic [39:0] m_en = '0;

  always #10 clk = ~clk;

  dual_cpu_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines_i(lines),
    .cpu0_irq_o(cpu0), .cpu1_irq_o(cpu1));

  function automatic logic exp_cpu0(logic [39:0] l, logic [39:0] e);
    return |(l & ~SHADOWS & e);
  endfunction

  function automatic logic exp_cpu1(logic [39:0] l, logic [39:0] e);
    return (l[30] & e[29]) | (l[5] & e[38]);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 8'h04) m_en[31:0] = d;
    if (a == 8'h50) m_en[39:32] = d[7:0];
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic check_all(string tag);
    logic [31:0] d;
    logic [39:0] p;
    p = lines & ~SHADOWS;
    chk({tag, " R7 cpu0"}, 32'(cpu0), 32'(exp_cpu0(lines, m_en)));
    chk({tag, " R8 cpu1"}, 32'(cpu1), 32'(exp_cpu1(lines, m_en)));
    rd(8'h04, d); chk({tag, " R2 en_lo"}, d, m_en[31:0]);
    rd(8'h50, d); chk({tag, " R3 en_hi"}, d, {24'd0, m_en[39:32]});
    rd(8'h08, d); chk({tag, " R4 pend_lo"}, d, p[31:0]);
    rd(8'h54, d); chk({tag, " R5 pend_hi"}, d, {24'd0, p[39:32]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state, with lines still low
    chk("R1 cpu0", 32'(cpu0), 32'd0);
    chk("R1 cpu1", 32'(cpu1), 32'd0);
    check_all("R1");

    // R3: upper bits of the high enable word ignore writes
    wr(8'h50, 32'hFFFF_FFFF);
    rd(8'h50, d); chk("R3 upper zero", d, 32'h0000_00FF);
    wr(8'h50, 32'h0);

    // R4: level tracking on line 3, no enable needed
    lines[3] = 1'b1; settle();
    rd(8'h08, d); chk("R4 held", d, 32'h8);
    lines[3] = 1'b0; settle();
    rd(8'h08, d); chk("R4 dropped", d, 32'h0);

    // R6: shadow line 29 asserted, its enable set -> nothing
    wr(8'h04, 32'h2000_0000);
    lines[29] = 1'b1; lines[38] = 1'b1; settle();
    chk("R6 cpu0", 32'(cpu0), 32'd0);
    chk("R6 cpu1", 32'(cpu1), 32'd0);
    rd(8'h08, d); chk("R6 pend_lo", d, 32'h0);
    rd(8'h54, d); chk("R6 pend_hi", d, 32'h0);
    lines = '0;

    // R8/R9: line 30 with own enable 0, shadow enable 1 -> CPU1 only
    lines[30] = 1'b1; settle();
    chk("R9 cpu0 off", 32'(cpu0), 32'd0);
    chk("R8 cpu1 on", 32'(cpu1), 32'd1);
    // own enable 1, shadow 0 -> CPU0 only
    wr(8'h04, 32'h4000_0000); settle();
    chk("R9 cpu0 on", 32'(cpu0), 32'd1);
    chk("R9 cpu1 off", 32'(cpu1), 32'd0);
    // unpaired line 7 with enable set never reaches CPU1
    lines = '0; lines[7] = 1'b1;
    wr(8'h04, 32'h80); settle();
    chk("R8 unpaired cpu1", 32'(cpu1), 32'd0);
    chk("R7 unpaired cpu0", 32'(cpu0), 32'd1);

    // R7 latency: line 2 settled high, enable write lands at edge 1, pin at edge 2
    wr(8'h04, 32'h0); lines = '0; lines[2] = 1'b1; settle();
    bus_addr = 8'h04; bus_wr = 1'b1; bus_wdata = 32'h4;
    @(negedge clk); bus_wr = 1'b0; m_en[31:0] = 32'h4;
    chk("R7 not yet", 32'(cpu0), 32'd0);
    @(negedge clk);
    chk("R7 two edges", 32'(cpu0), 32'd1);

    // R10: writes to pending and unused addresses have no effect
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h54, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R10 en_lo kept", d, 32'h4);
    rd(8'h50, d); chk("R10 en_hi kept", d, 32'h0);
    rd(8'h10, d); chk("R10 unused reads 0", d, 32'h0);

    // Random: line changes and enable writes on the same edge
    for (int i = 0; i < 300; i++) begin
      logic [7:0] a;
      case ($urandom % 5)
        0: a = 8'h04; 1: a = 8'h50; 2: a = 8'h08; 3: a = 8'h54; default: a = 8'h20;
      endcase
      lines = {$urandom, $urandom} & 40'hFF_FFFF_FFFF;
      if ($urandom % 4 == 0) lines = lines & {8{5'b00001}};
      wr(a, $urandom);
      settle();
      check_all("RND");
    end

    // R1 again: reset in mid-run clears enables
    rst = 1'b1; @(negedge clk); rst = 1'b0; m_en = '0;
    lines = '0; settle();
    check_all("R1 rerst");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule